// File: doc/BRIEF.md
# Remapped Display Output Serializer

This block builds the serial bit stream sent to a display driver chip. A frame covers the stream positions from zero up to a programmable last index. Each position is resolved in two steps. A writable map RAM holds one function code per position. That code then selects one bit of a function vector, which upstream font and grid logic supplies. The code can name a grid, a character segment, a decimal point, an annunciator or a cursor, so any stream position can drive any display function.

A host reaches the block through a simple register strobe port. One register sets the last stream position, and out-of-range values are clamped. A write-only pointer selects a map entry. A data register reads or writes the entry the pointer selects and then advances the pointer. A fixed identification register also reports a test-status input. Each frame starts on a one-cycle start pulse, and the block takes a snapshot of the function vector at that moment. Bits then leave at one per clock, highest position first. A one-cycle load strobe follows the last bit.

Top module: `bitmap_serializer`

## Requirements
- R1: After reset the last-position register holds 83, the map pointer is 0, map entry i holds code i, and ser_valid, ser_data and load are low.
- R2: A write of value v to register 0x0E stores v when v is at most 83 and stores 83 otherwise. A read of 0x0E returns the stored value in bits 6:0 with bit 7 zero.
- R3: A write of value v to the pointer register 0x06 sets the pointer to v, or to 83 when v exceeds 83. A read of 0x06 always returns 0x00.
- R4: A write of register 0x05 stores wr_data bits 6:0 into the entry the pointer selects. A read of 0x05 returns that entry zero-extended. Either access then advances the pointer by one, and it goes from 83 back to 0.
- R5: A read of register 0x07 returns 0b0000010 in bits 7:1 and test_active in bit 0. A read of any other unlisted address returns 0x00. Read data appears on reg_rdata in the cycle after the read strobe and holds until the next read.
- R6: A start pulse seen while idle begins a frame. ser_valid is high for exactly L+1 cycles, where L is the last-position value, and these cycles carry positions L, L-1, ..., 0 in that order.
- R7: Each frame uses the func_vec and func_ok values captured on its start cycle. Changes to those inputs during the frame do not change the bits sent.
- R8: When the position's code c is below 88, the bit sent is func_vec[c] AND func_ok[c]. Codes 88 to 127 always send 0.
- R9: When anno_en is low, codes 48 to 83 (the annunciator range) send 0.
- R10: A code whose func_ok bit is 0, meaning the font defines no such segment, sends 0 whatever func_vec holds.
- R11: load goes high for exactly one cycle, in the cycle right after the last bit of a frame.
- R12: A start pulse that arrives while a frame is running is ignored. It does not restart or lengthen the frame.
- R13: While ser_valid is low, ser_data is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| test_active | input | 1 | Display-test status reported in the ID register |
| anno_en | input | 1 | High when the current mode has annunciators |
| func_vec | input | 88 | Function bit values from font and grid logic |
| func_ok | input | 88 | Per-function flag marking whether the font defines the bit |
| start | input | 1 | Frame start pulse |
| ser_valid | output | 1 | High on each cycle that carries a stream bit |
| ser_data | output | 1 | Stream bit |
| load | output | 1 | One-cycle latch strobe after the last bit |

## Verification
A register write takes effect at the clock edge that samples it, so a read strobe in the next cycle already sees the new value. Read data is then due one edge after the read strobe. A start pulse sampled at edge E puts position L on the outputs right after E. Position L-k follows after edge E+k, and load follows after edge E+L+1. The bench drives every input on the falling edge and samples on the following falling edge. This places each comparison in the half cycle after the edge that produced the result, and the expected bit comes from a model of the map, the pointer and the captured vectors.

// File: rtl/bms_pkg.sv
package bms_pkg;
   localparam logic [7:0] ADDR_MAP_DATA = 8'h05;
   localparam logic [7:0] ADDR_MAP_PTR  = 8'h06;
   localparam logic [7:0] ADDR_IDENT    = 8'h07;
   localparam logic [7:0] ADDR_LAST_POS = 8'h0E;
   localparam logic [6:0] IDENT_BITS    = 7'b0000010;
endpackage

// File: rtl/bms_regs.sv
module bms_regs
   import bms_pkg::*;
#(
   parameter int N_POS  = 84,
   parameter int CODE_W = 7,
   parameter int AW     = $clog2(N_POS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [7:0]          addr,
   input  logic [7:0]          wr_data,
   input  logic                test_active,
   output logic [7:0]          rd_data,
   output logic [AW-1:0]       last_pos,
   input  logic [AW-1:0]       map_pos,
   output logic [CODE_W-1:0]   map_code
);
   localparam logic [AW-1:0] LAST    = AW'(N_POS - 1);
   localparam logic [7:0]    LAST_8B = 8'(N_POS - 1);

   logic [N_POS-1:0][CODE_W-1:0] map_q;
   logic [AW-1:0]                ptr_q;
   logic [AW-1:0]                last_q;
   logic                         data_hit;
   logic [AW-1:0]                ptr_next;

   assign data_hit = (wr_en || rd_en) && (addr == ADDR_MAP_DATA);
   assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
   assign last_pos = last_q;
   assign map_code = map_q[map_pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_POS; i++) map_q[i] <= CODE_W'(i);
         ptr_q   <= '0;
         last_q  <= LAST;
         rd_data <= '0;
      end else begin
         if (wr_en) begin
            unique case (addr)
               ADDR_LAST_POS: last_q <= (wr_data > LAST_8B) ? LAST : AW'(wr_data);
               ADDR_MAP_PTR:  ptr_q  <= (wr_data > LAST_8B) ? LAST : AW'(wr_data);
               ADDR_MAP_DATA: map_q[ptr_q] <= wr_data[CODE_W-1:0];
               default: ;
            endcase
         end
         if (rd_en) begin
            unique case (addr)
               ADDR_LAST_POS: rd_data <= 8'(last_q);
               ADDR_MAP_DATA: rd_data <= 8'(map_q[ptr_q]);
               ADDR_IDENT:    rd_data <= {IDENT_BITS, test_active};
               default:       rd_data <= '0;
            endcase
         end
         if (data_hit && !(wr_en && addr == ADDR_MAP_PTR)) ptr_q <= ptr_next;
      end
   end

   // R2
   last_range_chk: assert property (@(posedge clk) disable iff (!rst_n) last_q <= LAST);
   // R3
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr_q <= LAST);
   // R4
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_MAP_DATA && ptr_q == LAST) |=> (ptr_q == '0));
   // R5
   ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_IDENT) |=> (rd_data[7:1] == IDENT_BITS));
endmodule

// File: rtl/bms_resolve.sv
module bms_resolve #(
   parameter int CODE_W    = 7,
   parameter int FUNC_W    = 88,
   parameter int ANNO_LO   = 48,
   parameter int ANNO_HI   = 83,
   parameter bit ANNO_GATE = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              anno_en,
   input  logic [FUNC_W-1:0] func_vec,
   input  logic [FUNC_W-1:0] func_ok,
   output logic              bit_o
);
   localparam int IW = $clog2(FUNC_W);

   int unsigned code_u;
   logic        in_range;
   logic        anno_block;
   logic [IW-1:0] idx;

   assign code_u   = 32'(code);
   assign in_range = code_u < FUNC_W;
   assign idx      = in_range ? IW'(code_u) : '0;

   generate
      if (ANNO_GATE) begin : g_anno_gate
         assign anno_block = !anno_en && (code_u >= ANNO_LO) && (code_u <= ANNO_HI);
      end else begin : g_no_gate
         assign anno_block = 1'b0;
      end
   endgenerate

   assign bit_o = in_range && !anno_block && func_vec[idx] && func_ok[idx];
endmodule

// File: rtl/bms_shifter.sv
module bms_shifter #(
   parameter int AW     = 7,
   parameter int FUNC_W = 88
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     last_pos,
   input  logic [FUNC_W-1:0] func_vec,
   input  logic [FUNC_W-1:0] func_ok,
   input  logic              bit_in,
   output logic [AW-1:0]     pos,
   output logic [FUNC_W-1:0] snap_vec,
   output logic [FUNC_W-1:0] snap_ok,
   output logic              ser_valid,
   output logic              ser_data,
   output logic              load
);
   logic busy_q;
   logic load_q;
   logic [AW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         load_q   <= 1'b0;
         pos_q    <= '0;
         snap_vec <= '0;
         snap_ok  <= '0;
      end else begin
         load_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q   <= 1'b1;
               pos_q    <= last_pos;
               snap_vec <= func_vec;
               snap_ok  <= func_ok;
            end
         end else if (pos_q == '0) begin
            busy_q <= 1'b0;
            load_q <= 1'b1;
         end else begin
            pos_q <= pos_q - AW'(1);
         end
      end
   end

   assign pos       = pos_q;
   assign ser_valid = busy_q;
   assign ser_data  = busy_q && bit_in;
   assign load      = load_q;

   // R11
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) load |=> !load);
   // R11
   load_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_valid) |-> load);
   // R6
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && $past(ser_valid)) |-> (pos == $past(pos) - AW'(1)));
   // R7
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && $past(ser_valid)) |-> ($stable(snap_vec) && $stable(snap_ok)));
endmodule

// File: rtl/bitmap_serializer.sv
module bitmap_serializer #(
   parameter int N_POS     = 84,
   parameter int CODE_W    = 7,
   parameter int FUNC_W    = 88,
   parameter int ANNO_LO   = 48,
   parameter int ANNO_HI   = 83,
   parameter bit ANNO_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              test_active,
   input  logic              anno_en,
   input  logic [FUNC_W-1:0] func_vec,
   input  logic [FUNC_W-1:0] func_ok,
   input  logic              start,
   output logic              ser_valid,
   output logic              ser_data,
   output logic              load
);
   localparam int AW = $clog2(N_POS);

   generate
      if (N_POS < 2 || N_POS > 256) begin : g_bad_npos
         $error("N_POS must lie in 2..256");
      end
      if (CODE_W > 8) begin : g_bad_codew
         $error("CODE_W must fit the 8-bit data register");
      end
      if (FUNC_W > (1 << CODE_W)) begin : g_bad_funcw
         $error("FUNC_W exceeds the code space");
      end
      if (ANNO_HI >= FUNC_W || ANNO_LO > ANNO_HI) begin : g_bad_anno
         $error("annunciator range outside function vector");
      end
   endgenerate

   logic [AW-1:0]     last_pos;
   logic [AW-1:0]     pos;
   logic [CODE_W-1:0] code;
   logic [FUNC_W-1:0] snap_vec;
   logic [FUNC_W-1:0] snap_ok;
   logic              bit_sel;

   bms_regs #(.N_POS(N_POS), .CODE_W(CODE_W), .AW(AW)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
      .addr(reg_addr), .wr_data(reg_wdata), .test_active(test_active),
      .rd_data(reg_rdata), .last_pos(last_pos), .map_pos(pos), .map_code(code)
   );

   bms_resolve #(.CODE_W(CODE_W), .FUNC_W(FUNC_W), .ANNO_LO(ANNO_LO),
                 .ANNO_HI(ANNO_HI), .ANNO_GATE(ANNO_GATE)) i_resolve (
      .code(code), .anno_en(anno_en), .func_vec(snap_vec), .func_ok(snap_ok),
      .bit_o(bit_sel)
   );

   bms_shifter #(.AW(AW), .FUNC_W(FUNC_W)) i_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .last_pos(last_pos),
      .func_vec(func_vec), .func_ok(func_ok), .bit_in(bit_sel), .pos(pos),
      .snap_vec(snap_vec), .snap_ok(snap_ok), .ser_valid(ser_valid),
      .ser_data(ser_data), .load(load)
   );

   // R8
   unused_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && 32'(code) >= FUNC_W) |-> !ser_data);
   // R9
   anno_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ANNO_GATE && ser_valid && !anno_en && 32'(code) >= ANNO_LO && 32'(code) <= ANNO_HI) |-> !ser_data);
   // R13
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !ser_valid |-> !ser_data);
endmodule

// File: tb/test_bitmap_serializer.sv
module test_bitmap_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 84;
   localparam int FW = 88;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic test_active = 1'b0, anno_en = 1'b1, start = 1'b0;
   logic [FW-1:0] func_vec = '0, func_ok = '1;
   logic ser_valid, ser_data, load;

   int errs = 0;
   int checks = 0;
   logic [6:0] m_map [NP];
   int m_lim, m_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitmap_serializer i_bitmap_serializer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .test_active(test_active), .anno_en(anno_en), .func_vec(func_vec),
      .func_ok(func_ok), .start(start), .ser_valid(ser_valid),
      .ser_data(ser_data), .load(load)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp83(input int v);
      return (v > NP - 1) ? NP - 1 : v;
   endfunction

   function automatic bit exp_bit(input int p, input logic [FW-1:0] v,
                                  input logic [FW-1:0] o, input bit an);
      int c;
      c = int'(m_map[p]);
      if (c >= FW) return 1'b0;
      if (!an && c >= 48 && c <= 83) return 1'b0;
      return v[c] & o[c];
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         8'h0E: m_lim = clamp83(int'(d));
         8'h06: m_ptr = clamp83(int'(d));
         8'h05: begin m_map[m_ptr] = d[6:0]; m_ptr = (m_ptr == NP-1) ? 0 : m_ptr + 1; end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic rd_map_chk(input string req);
      logic [7:0] d;
      int e;
      e = int'(m_map[m_ptr]);
      rd(8'h05, d);
      m_ptr = (m_ptr == NP-1) ? 0 : m_ptr + 1;
      chk(d == 8'(e), req, int'(d), e);
   endtask

   task automatic run_frame(input bit mid_change, input bit mid_start);
      logic [FW-1:0] sv, so;
      bit an;
      @(negedge clk);
      start = 1'b1; sv = func_vec; so = func_ok; an = anno_en;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k <= m_lim; k++) begin
         if (k > 0) @(negedge clk);
         // R6 R7 R8 R9 R10: position m_lim-k with captured vectors
         chk(ser_valid == 1'b1, "R6 valid", int'(ser_valid), 1);
         chk(ser_data == exp_bit(m_lim - k, sv, so, an), "R7/R8 bit", int'(ser_data),
             int'(exp_bit(m_lim - k, sv, so, an)));
         if (k == 1 && mid_change) func_vec = ~func_vec;
         if (k == 1 && mid_start) start = 1'b1;
         if (k == 2) start = 1'b0;
      end
      start = 1'b0;
      @(negedge clk);
      // R11 load one cycle after last bit; R12 no restart
      chk(load == 1'b1, "R11 load high", int'(load), 1);
      chk(ser_valid == 1'b0, "R12 frame ended", int'(ser_valid), 0);
      @(negedge clk);
      chk(load == 1'b0, "R11 load single", int'(load), 0);
      chk(ser_valid == 1'b0 && ser_data == 1'b0, "R13 idle low", int'(ser_data), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240607));
      for (int i = 0; i < NP; i++) m_map[i] = 7'(i);
      m_lim = NP - 1; m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ser_valid == 0 && ser_data == 0 && load == 0, "R1 outputs idle", int'({ser_valid, ser_data, load}), 0);
      rd(8'h0E, d);
      chk(d == 8'd83, "R1 last position", int'(d), 83);
      rd_map_chk("R1 default entry 0");
      rd_map_chk("R1 default entry 1");
      // R1 default frame with identity map
      func_vec = FW'({$urandom, $urandom, $urandom});
      anno_en = 1'b0;
      run_frame(1'b0, 1'b0);
      // R5 ident
      test_active = 1'b0; rd(8'h07, d);
      chk(d == 8'h04, "R5 ident test=0", int'(d), 4);
      test_active = 1'b1; rd(8'h07, d);
      chk(d == 8'h05, "R5 ident test=1", int'(d), 5);
      rd(8'h33, d);
      chk(d == 8'h00, "R5 unlisted address", int'(d), 0);
      // R2 clamp
      wr(8'h0E, 8'hFF); rd(8'h0E, d); chk(d == 8'd83, "R2 clamp FF", int'(d), 83);
      wr(8'h0E, 8'h54); rd(8'h0E, d); chk(d == 8'd83, "R2 clamp 54", int'(d), 83);
      wr(8'h0E, 8'h00); rd(8'h0E, d); chk(d == 8'd0, "R2 zero", int'(d), 0);
      wr(8'h0E, 8'h21); rd(8'h0E, d); chk(d == 8'h21, "R2 mid value", int'(d), 33);
      // R3 pointer saturation and no read-back
      wr(8'h06, 8'hC0); rd(8'h06, d); chk(d == 8'h00, "R3 pointer unreadable", int'(d), 0);
      rd_map_chk("R3 saturated pointer selects 83");
      rd_map_chk("R4 pointer wraps to 0");
      // R4 write then read back
      wr(8'h06, 8'd10);
      wr(8'h05, 8'hE4); wr(8'h05, 8'h07);
      wr(8'h06, 8'd10);
      rd_map_chk("R4 readback 10");
      rd_map_chk("R4 readback 11");
      // R8 R9 R10 directed codes at positions 0..5
      wr(8'h06, 8'd0);
      wr(8'h05, 8'd100); wr(8'h05, 8'd50); wr(8'h05, 8'd87);
      wr(8'h05, 8'd10);  wr(8'h05, 8'd5);  wr(8'h05, 8'd127);
      wr(8'h0E, 8'd5);
      func_vec = '1; func_ok = '1; func_ok[10] = 1'b0;
      anno_en = 1'b0; run_frame(1'b0, 1'b0);
      anno_en = 1'b1; run_frame(1'b0, 1'b0);
      // R7 mid-frame change, R12 mid-frame start
      func_ok = '1;
      wr(8'h0E, 8'd9);
      run_frame(1'b1, 1'b1);
      wr(8'h0E, 8'd1);
      run_frame(1'b0, 1'b1);
      // constrained random
      for (int it = 0; it < 30; it++) begin
         wr(8'h06, 8'($urandom_range(0, 120)));
         for (int j = 0; j < 6; j++) wr(8'h05, 8'($urandom_range(0, 255)));
         wr(8'h0E, 8'($urandom_range(0, 255)));
         func_vec = FW'({$urandom, $urandom, $urandom});
         func_ok  = FW'({$urandom, $urandom, $urandom}) | FW'({$urandom, $urandom, $urandom});
         anno_en  = 1'($urandom_range(0, 1));
         run_frame(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         if (it % 5 == 0) rd_map_chk("R4 random readback");
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule